// File: doc/BRIEF.md
# Configurable Stereo Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial source (bit clock, word clock and data) and turns each received word into a parallel sample. It runs entirely in the system clock domain. The three serial lines pass through multi-stage synchronisers, and the bit clock is edge-detected after synchronisation. One configuration register, written through a small write port, selects the data format, the word length, the bit-clock edge used for sampling, and a dual-purpose bit. That bit sets the word-clock polarity in the justified and I2S formats, and selects early or late framing in the DSP short-frame format.

Each finished word appears on the left or right sample output with a one-cycle strobe, right-aligned in the sample bus. A framing error strobe flags a DSP frame sync that arrives before the current frame has delivered both of its words.

Writing the configuration register clears the framing state, so decoding starts fresh after a format change.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset, all outputs are 0, and the configuration register reads as 0: left justified, 16-bit words, normal word-clock polarity, late DSP framing, rising-edge sampling.
- R2: The configuration register is written only when `cfg_we` is 1 and `cfg_addr` equals 3. A write to any other address has no effect. Field layout: bit 1 is the polarity/early bit; bits 3:2 are the format (0 left justified, 1 right justified, 2 I2S, 3 DSP); bit 5 is the bit-clock invert; bits 7:6 are the word length (0 → 16, 1 → 20, 2 → 24, 3 → 32 bits). Bits 0 and 4 have no function.
- R3: Left justified: the MSB is on the first active edge after a word-clock change. A word-clock high half carries the left word.
- R4: Right justified: the word is the last N bits received before the next word-clock change, where N is the word length. A word-clock high half carries the left word.
- R5: I2S: the MSB is one active edge after the word-clock change. A word-clock low half carries the left word.
- R6: In the three non-DSP formats, bit 1 = 1 inverts the expected word-clock level, which swaps the channel assignment. The resulting one-sample offset between the channels is not compensated.
- R7: DSP late framing (bit 1 = 0): the first left bit is captured on the same active edge that sees the word clock go from low to high.
- R8: DSP early framing (bit 1 = 1): the first left bit is captured on the active edge after the one that sees the rise.
- R9: DSP: the right word immediately follows the left word, with no idle edges between them.
- R10: Bit 5 = 0 samples word clock and data on the rising bit-clock edge. Bit 5 = 1 samples them on the falling edge.
- R11: `frame_err` pulses for one cycle when, in DSP format, a word-clock rise arrives while the current frame has not yet delivered its right word. It never pulses in the other formats.
- R12: `left_vld` and `right_vld` are single-cycle strobes that follow an active bit-clock edge, and they are never high together.
- R13: Samples are MSB first and are delivered in the low N bits of the sample bus, with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W (4) | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| wclk_in | input | 1 | Serial word / frame clock |
| sdata_in | input | 1 | Serial data |
| left_data | output | SAMPLE_W (32) | Left sample, right-aligned |
| left_vld | output | 1 | Left sample strobe |
| right_data | output | SAMPLE_W (32) | Right sample, right-aligned |
| right_vld | output | 1 | Right sample strobe |
| frame_err | output | 1 | DSP framing error strobe |

## Verification
The assertions check a few things on every cycle. The two channel strobes never coincide and each follows a synchronised active edge. The active-edge pulse is a single cycle. A framing error is only raised under the DSP format, as a single pulse. A DSP right word is only delivered while a frame is open. Only the bench's serial scenarios can show the rest, each compared against values computed from the field layout: correct bit alignment in each of the four formats, the channel swap under inverted polarity, the one-edge shift of early DSP framing, falling-edge sampling, the word-length masking, and that writes to other addresses are ignored.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

   typedef enum logic [1:0] {
      FMT_LJ  = 2'd0,
      FMT_RJ  = 2'd1,
      FMT_I2S = 2'd2,
      FMT_DSP = 2'd3
   } fmt_e;

   // configuration register layout, MSB first
   typedef struct packed {
      logic [1:0] wl_code;    // 7:6 word length select
      logic       edge_inv;   // 5   sample on falling bit-clock edge
      logic       rsv4;       // 4   no function
      fmt_e       fmt;        // 3:2 serial format
      logic       pol_early;  // 1   word-clock polarity / DSP early framing
      logic       rsv0;       // 0   no function
   } cfg_t;

   function automatic int unsigned wl_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 20;
         2'd2:    return 24;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("asrx_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("asrx_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/asrx_edge.sv
module asrx_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_s,
   input  logic inv,
   output logic act
);
   logic bclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= bclk_s;
   end

   assign act = inv ? (bclk_d & ~bclk_s) : (bclk_s & ~bclk_d);

   // R10: one active edge yields exactly one pulse cycle
   p_act_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> !act);
endmodule

// File: rtl/asrx_cfg.sv
module asrx_cfg import asrx_pkg::*; #(
   parameter int          ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output cfg_t              cfg,
   output logic              wr_pulse
);
   assign wr_pulse = we && (addr == CFG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg <= '0;
      else if (wr_pulse) cfg <= cfg_t'(wdata);
   end

   // R2: register changes only through a matching write
   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_pulse) |-> $stable(cfg));
endmodule

// File: rtl/asrx_deframe.sv
module asrx_deframe import asrx_pkg::*; #(
   parameter int SAMPLE_W = 32,
   parameter int CNT_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                act,
   input  logic                w_in,
   input  logic                d_in,
   input  cfg_t                cfg,
   output logic [SAMPLE_W-1:0] l_data,
   output logic                l_vld,
   output logic [SAMPLE_W-1:0] r_data,
   output logic                r_vld,
   output logic                err
);
   localparam logic [CNT_W-1:0] CNT_SAT = '1;

   logic [SAMPLE_W-1:0] sr, full, mask, word;
   logic [CNT_W-1:0]    cnt, cur, inc, wl_n, off;
   logic w_prev, seen, busy;
   logic dsp, w_eff, chg, rise, cur_left;
   logic em_l, em_r, fe;

   always_comb begin
      dsp      = (cfg.fmt == FMT_DSP);
      w_eff    = dsp ? w_in : (w_in ^ cfg.pol_early);
      chg      = w_eff ^ w_prev;
      rise     = w_eff & ~w_prev;
      inc      = (cnt == CNT_SAT) ? cnt : cnt + 1'b1;
      cur      = (dsp ? rise : chg) ? '0 : inc;
      wl_n     = CNT_W'(wl_bits(cfg.wl_code));
      off      = CNT_W'(cfg.pol_early);
      full     = {sr[SAMPLE_W-2:0], d_in};
      for (int i = 0; i < SAMPLE_W; i++) mask[i] = (CNT_W'(i) < wl_n);
      cur_left = (cfg.fmt == FMT_I2S) ? ~w_eff : w_eff;
      word     = full & mask;
      em_l     = 1'b0;
      em_r     = 1'b0;
      fe       = 1'b0;
      if (!dsp) begin
         case (cfg.fmt)
            FMT_LJ:  if ((seen | chg) && cur == wl_n - 1'b1) begin
                        em_l = cur_left;  em_r = ~cur_left;
                     end
            FMT_I2S: if ((seen | chg) && cur == wl_n) begin
                        em_l = cur_left;  em_r = ~cur_left;
                     end
            default: if (chg && seen) begin
                        word = sr & mask;
                        em_l = w_prev;    em_r = ~w_prev;
                     end
         endcase
      end else begin
         fe = rise & busy;
         if (busy | rise) begin
            em_l = (cur == off + wl_n - 1'b1);
            em_r = (cur == off + (wl_n << 1) - 1'b1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;  cnt <= '0;  w_prev <= 1'b0;  seen <= 1'b0;  busy <= 1'b0;
         l_data <= '0;  r_data <= '0;  l_vld <= 1'b0;  r_vld <= 1'b0;  err <= 1'b0;
      end else begin
         l_vld <= 1'b0;
         r_vld <= 1'b0;
         err   <= 1'b0;
         if (clr) begin
            cnt <= '0;  w_prev <= 1'b0;  seen <= 1'b0;  busy <= 1'b0;
         end else if (act) begin
            sr     <= full;
            cnt    <= cur;
            w_prev <= w_eff;
            if (!dsp && chg) seen <= 1'b1;
            if (dsp) begin
               if (rise)      busy <= 1'b1;
               else if (em_r) busy <= 1'b0;
            end
            l_vld <= em_l;
            r_vld <= em_r;
            err   <= fe;
            if (em_l) l_data <= word;
            if (em_r) r_data <= word;
         end
      end
   end

   // R12: every strobe follows an active edge
   p_vld_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (l_vld || r_vld) |-> $past(act));
   // R11: framing error is a single pulse
   p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
   // R9: a DSP right word is only delivered from an open frame
   p_right_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (r_vld && dsp && $past(dsp)) |-> $past(busy));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx import asrx_pkg::*; #(
   parameter int SAMPLE_W    = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [7:0]          cfg_wdata,
   input  logic                bclk_in,
   input  logic                wclk_in,
   input  logic                sdata_in,
   output logic [SAMPLE_W-1:0] left_data,
   output logic                left_vld,
   output logic [SAMPLE_W-1:0] right_data,
   output logic                right_vld,
   output logic                frame_err
);
   localparam int CNT_W = $clog2(2 * SAMPLE_W + 2) + 1;

   if (SAMPLE_W < 32) begin : g_bad_sample_w
      $error("audio_serial_rx: SAMPLE_W must hold a 32-bit word");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("audio_serial_rx: ADDR_W must reach address 3");
   end

   cfg_t       cfg;
   logic       cfg_wr, act;
   logic [2:0] ser_s;
   logic       cfg_unused;

   assign cfg_unused = cfg.rsv4 ^ cfg.rsv0;

   asrx_cfg #(.ADDR_W(ADDR_W), .CFG_ADDR(ADDR_W'(3))) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .cfg(cfg), .wr_pulse(cfg_wr));

   asrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .din({bclk_in, wclk_in, sdata_in}), .dout(ser_s));

   asrx_edge u_edge (
      .clk(clk), .rst_n(rst_n), .bclk_s(ser_s[2]),
      .inv(cfg.edge_inv), .act(act));

   asrx_deframe #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_deframe (
      .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .act(act),
      .w_in(ser_s[1]), .d_in(ser_s[0]), .cfg(cfg),
      .l_data(left_data), .l_vld(left_vld),
      .r_data(right_data), .r_vld(right_vld), .err(frame_err));

   // R12: channel strobes never coincide
   p_vld_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(left_vld && right_vld));
   // R11: framing errors only under the DSP format
   p_err_dsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> ($past(cfg.fmt) == FMT_DSP));
endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SW  = 32;
   localparam int HB  = 34;          // bits per half-frame, non-DSP
   localparam int DF  = 2 * SW + 8;  // bits per DSP frame
   localparam int NV  = 11;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic bclk_in = 1'b0, wclk_in = 1'b0, sdata_in = 1'b0;
   logic [SW-1:0] left_data, right_data;
   logic left_vld, right_vld, frame_err;

   int tests = 0, fails = 0;
   int nerr = 0, nboth = 0;
   logic [SW-1:0] mon_l = '0, mon_r = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_serial_rx u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .bclk_in(bclk_in), .wclk_in(wclk_in),
      .sdata_in(sdata_in), .left_data(left_data), .left_vld(left_vld),
      .right_data(right_data), .right_vld(right_vld), .frame_err(frame_err));

   always @(negedge clk) begin
      if (left_vld)  mon_l = left_data;
      if (right_vld) mon_r = right_data;
      if (frame_err) nerr++;
      if (left_vld && right_vld) nboth++;
   end

   // cfg, first word sent, second word sent
   localparam logic [71:0] VEC [NV] = '{
      {8'h00, 32'h0000_A5C3, 32'h0000_3C5A},   // R3 LJ 16
      {8'h82, 32'h00AB_CDEF, 32'h0012_3456},   // R3 R6 LJ 24 inverted
      {8'h44, 32'h000F_1E2D, 32'h0007_8A9B},   // R4 RJ 20
      {8'hC6, 32'hDEAD_BEEF, 32'h1357_9BDF},   // R4 R6 RJ 32 inverted
      {8'h08, 32'h0000_8001, 32'h0000_7FFE},   // R5 I2S 16
      {8'hCA, 32'hF0E1_D2C3, 32'h0F1E_2D3C},   // R5 R6 I2S 32 inverted
      {8'h0C, 32'h0000_C3A5, 32'h0000_5AC3},   // R7 R9 DSP late 16
      {8'h8E, 32'h0089_ABCD, 32'h0076_5432},   // R8 R9 DSP early 24
      {8'h60, 32'h000A_BCDE, 32'h0001_2345},   // R10 LJ 20 falling edge
      {8'hEC, 32'h8765_4321, 32'h2468_ACE0},   // R10 R7 DSP late 32 falling
      {8'hA8, 32'hFFFF_FFFF, 32'h0055_AA55}    // R10 R13 I2S 24, upper bits masked
   };

   function automatic int wlen(input logic [7:0] c);
      case (c[7:6])
         2'd0: return 16;  2'd1: return 20;  2'd2: return 24;  default: return 32;
      endcase
   endfunction

   function automatic logic [SW-1:0] msk(input logic [SW-1:0] v, input int n);
      logic [SW-1:0] r;
      for (int i = 0; i < SW; i++) r[i] = (i < n) ? v[i] : 1'b0;
      return r;
   endfunction

   task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1;  cfg_addr = a;  cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // non-active level, data change mid-phase, then active edge
   task automatic send_bit(input logic inv, input logic w, input logic d);
      @(negedge clk);  bclk_in = inv;
      repeat (2) @(negedge clk);
      wclk_in = w;  sdata_in = d;
      repeat (2) @(negedge clk);
      bclk_in = ~inv;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] c, input logic [SW-1:0] a, input logic [SW-1:0] b);
      int n;
      logic inv, pol;
      n = wlen(c);  inv = c[5];  pol = c[1];
      if (c[3:2] == 2'd3) begin
         for (int j = 0; j < DF; j++) begin
            int k;
            logic d;
            k = j - int'(pol);
            d = 1'b0;
            if (k >= 0 && k < n)            d = a[n-1-k];
            else if (k >= n && k < 2 * n)   d = b[2*n-1-k];
            send_bit(inv, j == 0, d);
         end
      end else begin
         for (int h = 0; h < 2; h++) begin
            logic [SW-1:0] wd;
            wd = (h == 0) ? a : b;
            for (int j = 0; j < HB; j++) begin
               logic d;
               d = 1'b0;
               case (c[3:2])
                  2'd0:    if (j < n) d = wd[n-1-j];
                  2'd2:    if (j >= 1 && j <= n) d = wd[n-j];
                  default: if (j >= HB - n) d = wd[HB-1-j];
               endcase
               send_bit(inv, h == 0, d);
            end
         end
      end
   endtask

   task automatic run_vec(input logic [7:0] c, input logic [SW-1:0] a, input logic [SW-1:0] b,
                          input string tag);
      logic swap;
      int n;
      n = wlen(c);
      swap = (c[3:2] != 2'd3) && (c[1] ^ (c[3:2] == 2'd2));
      wr_cfg(4'd3, c);
      send_frame(c, a, b);
      send_frame(c, a, b);
      send_bit(c[5], c[3:2] != 2'd3, 1'b0);
      repeat (12) @(negedge clk);
      check({tag, " left"},  mon_l, swap ? msk(b, n) : msk(a, n));
      check({tag, " right"}, mon_r, swap ? msk(a, n) : msk(b, n));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 left_data",  left_data, '0);
      check("R1 right_data", right_data, '0);
      check("R1 strobes",    SW'({left_vld, right_vld, frame_err}), '0);

      // R1 default config decodes LJ 16-bit without any write
      send_frame(8'h00, 32'h0000_1234, 32'h0000_8765);
      send_bit(1'b0, 1'b1, 1'b0);
      repeat (12) @(negedge clk);
      check("R1 default left",  mon_l, 32'h0000_1234);
      check("R1 default right", mon_r, 32'h0000_8765);

      for (int v = 0; v < NV; v++) begin
         logic [71:0] e;
         e = VEC[v];
         run_vec(e[71:64], e[63:32], e[31:0], $sformatf("R13 vec%0d", v));
      end
      check("R11 no error outside DSP", SW'(nerr), 32'd2 * 0);

      // R2: write to address 2 is ignored, LJ 16 stays active
      wr_cfg(4'd3, 8'h00);
      wr_cfg(4'd2, 8'h0C);
      send_frame(8'h00, 32'h0000_4E71, 32'h0000_B18E);
      send_bit(1'b0, 1'b1, 1'b0);
      repeat (12) @(negedge clk);
      check("R2 ignored addr left",  mon_l, 32'h0000_4E71);
      check("R2 ignored addr right", mon_r, 32'h0000_B18E);

      // R11: DSP frame cut short by a new sync
      wr_cfg(4'd3, 8'h0C);
      send_bit(1'b0, 1'b1, 1'b1);
      for (int j = 0; j < 9; j++) send_bit(1'b0, 1'b0, 1'b1);
      send_frame(8'h0C, 32'h0000_6D2B, 32'h0000_92D4);
      send_bit(1'b0, 1'b0, 1'b0);
      repeat (12) @(negedge clk);
      check("R11 error count", SW'(nerr), 32'd1);
      check("R11 recovered left",  mon_l, 32'h0000_6D2B);
      check("R11 recovered right", mon_r, 32'h0000_92D4);

      check("R12 strobes exclusive", SW'(nboth), 32'd0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule